// File: doc/BRIEF.md
# Rotor Lock Protection Timer

This block watches the three Hall sensor bits of a brushless motor while the drive is running and measures how long they have stayed frozen. Time is measured in pulses of a slow tick supplied by an external timing source; one tick is one unit of the protection window. If the Hall value has not changed by the time a configurable number of ticks has elapsed, the rotor is considered stalled. The block then raises a lock flag and forces the high-side gate drivers off.

Recovery is automatic. The lock is held for one further window of the same length. After that the flag drops and monitoring starts again from zero, so a stalled motor gets periodic retry attempts. Entering power-save clears both the lock and the elapsed count at once. An over-temperature condition only freezes the count and leaves its value intact, so timing resumes where it stopped once the temperature condition goes away. The window length is the parameter `TIMEOUT_TICKS`. With a 1 ms tick, the default of 2000 gives the usual window of about two seconds.

Top module: `rotor_lock_timer`

## Requirements
- R1: While reset is asserted and directly after it, `lock_o` and `hs_off_o` are 0.
- R2: With drive active, no power-save, no over-temperature and an unchanging Hall value, `lock_o` rises at the clock edge that samples the `TIMEOUT_TICKS`-th tick pulse. After `TIMEOUT_TICKS`-1 ticks it is still 0.
- R3: `hs_off_o` equals `lock_o` in every cycle.
- R4: A change of the Hall value relative to the value sampled at the previous clock edge restarts the count from zero. A full `TIMEOUT_TICKS` of new ticks is then needed to lock.
- R5: While `drive_en_i` is 0 and no lock is active, the count is held at zero and no lock can be declared.
- R6: While `ovtemp_i` is 1, ticks are ignored and the count keeps its value. After release, only the remaining ticks are needed.
- R7: `psave_i` at a clock edge clears the lock and the count, with priority over every other input.
- R8: Once locked, the lock clears at the edge that samples the `TIMEOUT_TICKS`-th further tick, and monitoring restarts from a count of zero.
- R9: Hall changes and a low `drive_en_i` during a lock do not shorten the lock window.
- R10: Clock cycles without a tick pulse do not advance the count. Each cycle with `tick_i` high advances it by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | HALL_W | Hall sensor bits, already synchronised |
| drive_en_i | input | 1 | Motor is being driven |
| psave_i | input | 1 | Power-save request; clears lock and count |
| ovtemp_i | input | 1 | Over-temperature shutdown; freezes the count |
| tick_i | input | 1 | One-cycle pulse of the slow timing source |
| lock_o | output | 1 | Locked-rotor condition active |
| hs_off_o | output | 1 | Force high-side gates off |

## Verification
The bench builds the block with `TIMEOUT_TICKS` = 5 and `HALL_W` = 3. This puts the lock threshold, the whole retry window and a second lock after retry within a few dozen cycles. The small window also makes off-by-one errors at the threshold visible: a lock one tick early or one tick late, a frozen count that is wrongly cleared, or a count that is not cleared after power-save or a Hall change all show up as a wrong output at a known tick.

// File: rtl/rlk_pkg.sv
package rlk_pkg;
  typedef enum logic {
    RLK_WATCH  = 1'b0,
    RLK_LOCKED = 1'b1
  } rlk_state_e;
endpackage

// File: rtl/hall_change_det.sv
// Registers the Hall bits and flags any difference from the previous sample.
module hall_change_det #(
  parameter int HALL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALL_W-1:0] hall_i,
  output logic              changed_o
);
  logic [HALL_W-1:0] hall_q;
  logic [HALL_W-1:0] hall_d;

  always_comb begin
    hall_d = hall_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hall_q <= '0;
    else        hall_q <= hall_d;
  end

  assign changed_o = (hall_i != hall_q);
endmodule

// File: rtl/tick_window_counter.sv
// Counts tick pulses up to LIMIT. Clear has priority over hold.
// done_o pulses on the tick that completes the window; the count then wraps to zero.
module tick_window_counter #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic hold_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign cnt_en  = clr_i | (tick_i & ~hold_i);
  assign done_o  = ~clr_i & ~hold_i & tick_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lock_fsm.sv
// Two-state control: watch for a stall, then hold the lock for one window.
module lock_fsm
  import rlk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic psave_i,
  input  logic drive_en_i,
  input  logic hall_changed_i,
  input  logic window_done_i,
  output logic cnt_clr_o,
  output logic locked_o
);
  rlk_state_e state_q;
  rlk_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (psave_i) begin
      state_d = RLK_WATCH;
    end else begin
      case (state_q)
        RLK_WATCH:  if (window_done_i) state_d = RLK_LOCKED;
        RLK_LOCKED: if (window_done_i) state_d = RLK_WATCH;
        default:    state_d = RLK_WATCH;
      endcase
    end
  end

  always_comb begin
    cnt_clr_o = psave_i;
    if (state_q == RLK_WATCH && (!drive_en_i || hall_changed_i)) cnt_clr_o = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RLK_WATCH;
    else        state_q <= state_d;
  end

  assign locked_o = (state_q == RLK_LOCKED);
endmodule

// File: rtl/rotor_lock_timer.sv
module rotor_lock_timer #(
  parameter int TIMEOUT_TICKS = 2000,
  parameter int HALL_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALL_W-1:0] hall_i,
  input  logic              drive_en_i,
  input  logic              psave_i,
  input  logic              ovtemp_i,
  input  logic              tick_i,
  output logic              lock_o,
  output logic              hs_off_o
);
  logic hall_changed;
  logic window_done;
  logic cnt_clr;
  logic locked;

  hall_change_det #(.HALL_W(HALL_W)) u_hall (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_i    (hall_i),
    .changed_o (hall_changed)
  );

  tick_window_counter #(.LIMIT(TIMEOUT_TICKS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .hold_i (ovtemp_i),
    .tick_i (tick_i),
    .done_o (window_done)
  );

  lock_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .psave_i        (psave_i),
    .drive_en_i     (drive_en_i),
    .hall_changed_i (hall_changed),
    .window_done_i  (window_done),
    .cnt_clr_o      (cnt_clr),
    .locked_o       (locked)
  );

  assign lock_o   = locked;
  assign hs_off_o = locked;
endmodule

// File: rtl/rotor_lock_timer_chk.sv
module rotor_lock_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic drive_en_i,
  input logic psave_i,
  input logic ovtemp_i,
  input logic tick_i,
  input logic lock_o,
  input logic hs_off_o
);
  assert_hs_follows_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_off_o == lock_o);

  assert_psave_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    psave_i |=> !lock_o);

  assert_idle_never_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_en_i && !lock_o) |=> !lock_o);

  assert_ovtemp_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovtemp_i && !psave_i) |=> $stable(lock_o));

  assert_lock_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(tick_i));

  assert_release_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> ($past(tick_i) || $past(psave_i)));
endmodule

bind rotor_lock_timer rotor_lock_timer_chk u_chk (.*);

// File: tb/rotor_lock_timer_tb.sv
module rotor_lock_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hall;
  logic       drive_en, psave, ovtemp, tick;
  logic       lock_o, hs_off_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic  exp_lock;
    string req;
  } item_t;

  item_t q[$];
  event  ev_sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotor_lock_timer #(.TIMEOUT_TICKS(LIM), .HALL_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .drive_en_i(drive_en),
    .psave_i(psave), .ovtemp_i(ovtemp), .tick_i(tick),
    .lock_o(lock_o), .hs_off_o(hs_off_o)
  );

  // monitor: compares outputs against queued expectations
  initial begin
    forever begin
      @(ev_sample);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_tests++;
        if (lock_o !== it.exp_lock) begin
          n_fail++;
          $display("FAIL %s lock_o actual=%b expected=%b", it.req, lock_o, it.exp_lock);
        end
        n_tests++;
        if (hs_off_o !== it.exp_lock) begin
          n_fail++;
          $display("FAIL R3 (%s) hs_off_o actual=%b expected=%b", it.req, hs_off_o, it.exp_lock);
        end
      end
    end
  end

  task automatic expect_lock(input logic e, input string req);
    item_t it;
    it.exp_lock = e;
    it.req = req;
    q.push_back(it);
    ->ev_sample;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic psave_pulse();
    psave = 1'b1;
    @(negedge clk);
    psave = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hall = 3'b001; drive_en = 1'b1; psave = 1'b0;
    ovtemp = 1'b0; tick = 1'b0;
    idle(2);
    expect_lock(1'b0, "R1 in reset");
    rst_n = 1'b1;
    idle(2);
    expect_lock(1'b0, "R1 after reset");

    // R2: threshold
    ticks(LIM-1);
    expect_lock(1'b0, "R2 one tick short");
    ticks(1);
    expect_lock(1'b1, "R2 lock at limit");

    // R9: hall activity and drive off during lock do not shorten it
    hall = 3'b011; idle(1);
    drive_en = 1'b0;
    ticks(LIM-1);
    expect_lock(1'b1, "R9 lock held");
    drive_en = 1'b1;
    ticks(1);
    expect_lock(1'b0, "R8 auto release");
    ticks(LIM-1);
    expect_lock(1'b0, "R8 restart from zero");
    ticks(1);
    expect_lock(1'b1, "R8 relock after retry");

    // R7: power-save clears lock and count
    psave_pulse();
    expect_lock(1'b0, "R7 lock cleared");
    ticks(LIM-1);
    expect_lock(1'b0, "R7 count cleared");

    // R4: hall change restarts count
    hall = 3'b010; idle(1);
    ticks(LIM-1);
    expect_lock(1'b0, "R4 count restarted");
    ticks(1);
    expect_lock(1'b1, "R4 lock after fresh window");
    psave_pulse();
    expect_lock(1'b0, "R7 clear before R6");

    // R6: over-temperature freezes
    ticks(3);
    ovtemp = 1'b1;
    ticks(LIM);
    expect_lock(1'b0, "R6 frozen");
    ovtemp = 1'b0;
    ticks(1);
    expect_lock(1'b0, "R6 resumed count");
    ticks(1);
    expect_lock(1'b1, "R6 lock after remaining ticks");
    psave_pulse();

    // R5: drive off holds count at zero
    ticks(2);
    drive_en = 1'b0;
    ticks(2*LIM);
    expect_lock(1'b0, "R5 no lock while idle");
    drive_en = 1'b1;
    ticks(LIM-1);
    expect_lock(1'b0, "R5 count was zero");
    ticks(1);
    expect_lock(1'b1, "R5 lock after full window");
    psave_pulse();

    // R10: idle cycles do not count
    ticks(LIM-1);
    idle(20);
    expect_lock(1'b0, "R10 no tick no advance");
    ticks(1);
    expect_lock(1'b1, "R10 lock on tick");

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule